// File: doc/BRIEF.md
# Auto-Reload Interval Timer Interrupt

A 24-bit down-counter that runs on the processor clock and reloads itself from a programmable reload register each time it reaches zero. Every pass through zero raises an active-low interrupt. The interrupt is either a short fixed-width pulse for edge-sensitive interrupt controllers, or a level that stays asserted until software acknowledges it.

Software talks to the block through a byte-wide write port. Three configuration bytes hold the reload value. Configuration byte 0 takes operation opcodes: start, stop, select pulse mode, select level mode and acknowledge. The running count cannot be read back. The timer comes out of reset stopped, so software writes the reload value first and then issues the start opcode.

Top module: `interval_timer`

## Requirements
- R1: After reset the timer is stopped, the interrupt mode is pulse, and `irq_no` stays high until a start opcode is written.
- R2: Writing opcode 0x01 (start) to byte 0 loads the counter from the reload register. With reload value R, the first interrupt is asserted R+1 clock cycles after the write is sampled, and interrupts then repeat every R+1 cycles.
- R3: Bytes 4, 5 and 6 hold reload bits 7:0, 15:8 and 23:16. A reload value written while the timer runs takes effect at the next terminal count.
- R4: In pulse mode (opcode 0x04 written to byte 0), each terminal count drives `irq_no` low for exactly two clock cycles.
- R5: In level mode (opcode 0x05 written to byte 0), `irq_no` goes low at terminal count. It stays low until opcode 0x08 (acknowledge) is written to byte 0, and goes high on the cycle after that write.
- R6: In level mode, further terminal counts while the interrupt is pending keep `irq_no` low. An acknowledge written in the same cycle as a terminal count leaves `irq_no` low.
- R7: Opcode 0x02 (stop), or either mode-select opcode, drives `irq_no` high on the next cycle and clears any pending or in-progress interrupt. After a stop, no further interrupts occur.
- R8: Writes to addresses 1, 2, 3 and 7, and unknown opcodes written to byte 0, change neither the timer nor the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 3 | Configuration byte address |
| cfg_data_i | input | 8 | Configuration write data |
| irq_no | output | 1 | Active-low timer interrupt |

## Verification
The hardest case to reach is an acknowledge that lands on exactly the same edge as a fresh terminal count in level mode. The count is not visible, so the bench works out the phase itself: it starts the timer on a known edge, counts clock cycles from there, and issues the acknowledge so that it is sampled on the second terminal-count edge. Each stage of this is checked at the output. Level mode must keep the line low across a repeated terminal count, must keep it low through the coincident acknowledge, and must release it after a later acknowledge.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  typedef enum logic [7:0] {
    OP_START = 8'h01,
    OP_STOP  = 8'h02,
    OP_EDGE  = 8'h04,
    OP_LEVEL = 8'h05,
    OP_ACK   = 8'h08
  } op_e;

  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } irq_mode_e;
endpackage

// File: rtl/itmr_cfg.sv
module itmr_cfg
  import itmr_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int RELOAD_BASE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]       data_i,
  output logic [CNT_W-1:0] reload_o,
  output logic             start_o,
  output logic             stop_o,
  output logic             ack_o,
  output logic             mode_chg_o,
  output irq_mode_e        mode_o
);
  localparam int NUM_BYTES = CNT_W / 8;

  logic [CNT_W-1:0] reload_q;
  irq_mode_e        mode_q;
  logic             op_hit;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_lane
    localparam int LANE_ADDR = RELOAD_BASE + b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) reload_q[b*8 +: 8] <= '0;
      else if (we_i && addr_i == ADDR_W'(LANE_ADDR)) reload_q[b*8 +: 8] <= data_i;
    end
  end

  assign op_hit     = we_i && (addr_i == '0);
  assign start_o    = op_hit && (data_i == OP_START);
  assign stop_o     = op_hit && (data_i == OP_STOP);
  assign ack_o      = op_hit && (data_i == OP_ACK);
  assign mode_chg_o = op_hit && ((data_i == OP_EDGE) || (data_i == OP_LEVEL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         mode_q <= MODE_EDGE;
    else if (mode_chg_o) mode_q <= (data_i == OP_LEVEL) ? MODE_LEVEL : MODE_EDGE;
  end

  assign reload_o = reload_q;
  assign mode_o   = mode_q;

  p_mode_sel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_chg_o |=> (mode_o == (($past(data_i) == OP_LEVEL) ? MODE_LEVEL : MODE_EDGE)));
  p_no_stray_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i < ADDR_W'(RELOAD_BASE))) |=> $stable(reload_o));
endmodule

// File: rtl/itmr_core.sv
module itmr_core #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             tc_o
);
  logic             en_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      en_q <= 1'b0;
    end else if (start_i) begin
      en_q  <= 1'b1;
      cnt_q <= reload_i;
    end else if (en_q) begin
      cnt_q <= (cnt_q == '0) ? reload_i : cnt_q - 1'b1;
    end
  end

  assign tc_o = en_q && (cnt_q == '0);

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == $past(reload_i)));
  p_auto_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !start_i && !stop_i) |=> (cnt_q == $past(reload_i)));
  p_count_down_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && cnt_q != '0 && !start_i && !stop_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
  p_stop_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !tc_o);
endmodule

// File: rtl/itmr_irq.sv
module itmr_irq
  import itmr_pkg::*;
#(
  parameter int PULSE_LEN = 2
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tc_i,
  input  logic      clr_i,
  input  logic      ack_i,
  input  irq_mode_e mode_i,
  output logic      irq_no
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] pulse_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_q <= '0;
      pend_q  <= 1'b0;
    end else if (clr_i) begin
      pulse_q <= '0;
      pend_q  <= 1'b0;
    end else if (mode_i == MODE_EDGE) begin
      pend_q  <= 1'b0;
      if (tc_i)               pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0) pulse_q <= pulse_q - 1'b1;
    end else begin
      pulse_q <= '0;
      // a new terminal count outranks a coincident acknowledge
      pend_q  <= tc_i || (pend_q && !ack_i);
    end
  end

  assign irq_no = !(pend_q || (pulse_q != '0));

  p_clear_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> irq_no);
  p_tc_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_i && !clr_i) |=> !irq_no);
  p_pulse_second_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_EDGE && $fell(irq_no) && !clr_i) |=> !irq_no);
  p_level_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL && !irq_no && !ack_i && !clr_i) |=> !irq_no);
  p_ack_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_LEVEL && ack_i && !tc_i) |=> irq_no);
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import itmr_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 3,
  parameter int RELOAD_BASE = 4,
  parameter int PULSE_LEN   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [7:0]        cfg_data_i,
  output logic              irq_no
);
  logic [CNT_W-1:0] reload;
  logic             start, stop, ack, mode_chg, tc;
  irq_mode_e        mode;

  itmr_cfg #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RELOAD_BASE(RELOAD_BASE)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .data_i(cfg_data_i), .reload_o(reload), .start_o(start), .stop_o(stop),
    .ack_o(ack), .mode_chg_o(mode_chg), .mode_o(mode)
  );

  itmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .stop_i(stop),
    .reload_i(reload), .tc_o(tc)
  );

  itmr_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .tc_i(tc), .clr_i(stop || mode_chg),
    .ack_i(ack), .mode_i(mode), .irq_no(irq_no)
  );
endmodule

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] data = '0;
  logic       irq_n;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  interval_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
    .cfg_data_i(data), .irq_no(irq_n)
  );

  localparam int VEC_N = 5;
  localparam int VEC_RL [VEC_N] = '{2, 3, 7, 20, 12};
  localparam bit VEC_LV [VEC_N] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is sampled on the next posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; data = d;
    @(negedge clk);
    we = 1'b0; addr = '0; data = '0;
  endtask

  task automatic set_reload(input int r);
    wr(3'd4, 8'(r));
    wr(3'd5, 8'(r >> 8));
    wr(3'd6, 8'(r >> 16));
  endtask

  task automatic wait_fall(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (irq_n !== 1'b0 && n < limit);
  endtask

  // from a low sample: width of current low phase, cycles to next fall
  task automatic measure(output int w, output int k);
    bit seen_high = 1'b0;
    w = 1; k = 0;
    while (k < 1000) begin
      @(negedge clk);
      k++;
      if (irq_n) seen_high = 1'b1;
      else if (!seen_high) w++;
      else break;
    end
  endtask

  task automatic stays_high(input int n, input string req);
    int lows = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_n !== 1'b1) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act 0 exp 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n, w, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq_n === 1'b1, "R1 reset", int'(irq_n), 1);
    set_reload(3);
    stays_high(30, "R1 idle until start");

    // vector table
    for (int v = 0; v < VEC_N; v++) begin
      wr(3'd0, 8'h02);
      set_reload(VEC_RL[v]);
      wr(3'd0, VEC_LV[v] ? 8'h05 : 8'h04);
      wr(3'd0, 8'h01);
      wait_fall(2000, n);
      chk(n == VEC_RL[v] + 1, "R2 first interrupt", n, VEC_RL[v] + 1);
      if (!VEC_LV[v]) begin
        measure(w, k);
        chk(w == 2, "R4 pulse width", w, 2);
        chk(k == VEC_RL[v] + 1, "R2 period", k, VEC_RL[v] + 1);
      end else begin
        repeat (5) @(negedge clk);
        chk(irq_n === 1'b0, "R5 level held", int'(irq_n), 0);
        wr(3'd0, 8'h08);
        chk(irq_n === 1'b1, "R5 ack release", int'(irq_n), 1);
      end
    end

    // R3 multi-byte reload: 0x000103 = 259
    wr(3'd0, 8'h02);
    wr(3'd0, 8'h04);
    wr(3'd4, 8'h03); wr(3'd5, 8'h01); wr(3'd6, 8'h00);
    wr(3'd0, 8'h01);
    wait_fall(2000, n);
    chk(n == 260, "R3 bytes 4,5", n, 260);
    // R3 top byte: 0x010000
    wr(3'd0, 8'h02);
    wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h01);
    wr(3'd0, 8'h01);
    wait_fall(70000, n);
    chk(n == 65537, "R3 byte 6", n, 65537);

    // R3 reload rewritten while running
    wr(3'd0, 8'h02);
    set_reload(4);
    wr(3'd0, 8'h01);
    wait_fall(100, n);
    set_reload(10);
    wait_fall(100, n);
    measure(w, k);
    chk(k == 11, "R3 new reload at next tc", k, 11);

    // R7 stop halts interrupts
    wr(3'd0, 8'h02);
    chk(irq_n === 1'b1, "R7 stop releases", int'(irq_n), 1);
    stays_high(40, "R7 no interrupt after stop");

    // R8 stray writes: start opcode on address 2, junk to 1, 3 and 7
    set_reload(6);
    wr(3'd2, 8'h01); wr(3'd1, 8'h01); wr(3'd3, 8'h01); wr(3'd7, 8'h55);
    stays_high(30, "R8 stray start ignored");
    wr(3'd0, 8'h01);
    wait_fall(100, n);
    chk(n == 7, "R8 reload untouched", n, 7);

    // R6 level: hold across tc, coincident ack stays low
    wr(3'd0, 8'h02);
    set_reload(5);
    wr(3'd0, 8'h05);
    wr(3'd0, 8'h01);             // sampled at E0; tc at E6, E12
    repeat (6) @(negedge clk);
    chk(irq_n === 1'b0, "R5 level asserts", int'(irq_n), 0);
    wr(3'd0, 8'h7F);             // unknown opcode at E7
    chk(irq_n === 1'b0, "R8 unknown opcode", int'(irq_n), 0);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h08);             // ack sampled at E12 with tc
    chk(irq_n === 1'b0, "R6 ack with tc stays low", int'(irq_n), 0);
    wr(3'd0, 8'h08);             // E13, no tc
    chk(irq_n === 1'b1, "R5 later ack releases", int'(irq_n), 1);
    repeat (5) @(negedge clk);
    chk(irq_n === 1'b0, "R6 next tc", int'(irq_n), 0);
    repeat (12) @(negedge clk);
    chk(irq_n === 1'b0, "R6 held across repeated tc", int'(irq_n), 0);

    // R7 mode select clears a pending level interrupt
    wr(3'd0, 8'h04);
    chk(irq_n === 1'b1, "R7 mode switch releases", int'(irq_n), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule